// File: doc/BRIEF.md
# Flash Page-Program Write Buffer

This block is the program path of a serial NOR flash controller. It holds a page of data, supplied by software as 32-bit words, and sends that page to the flash in one page-program transaction. One storage array serves two roles. In the read-prefetch role it ignores page data. In the program role it accepts page words. A role request input selects the role, and an acknowledge output reports the role that is actually in effect, so software can poll for the switch to complete.

A page command sends the flash program opcode, the address and every buffered byte while chip select stays low for the whole transaction. When the transfer ends, the command clears itself. A single-byte command programs one byte from a separate data input at the current address and then advances that address by one. Software uses it for tails shorter than a page. The serial link carries one bit for every two clock cycles on a single data lane, most significant bit first.

Top module: `pp_wbuf`

## Requirements
- R1: During and right after reset, `busy_o`=0, `cs_no`=1, `sclk_o`=0 and `mode_ack_o`=0 (read-prefetch role).
- R2: While idle, `mode_ack_o` takes the value of `mode_prog_i` one cycle later. While busy, it holds its value.
- R3: Word k of a page supplies bytes 4k..4k+3. Byte 4k+j comes from bits 8j+7:8j, and the data bytes go out in order from byte 0 to byte 127.
- R4: A word written while the block is busy, in the read role, or after 32 words are already held is dropped, and the stored bytes stay unchanged.
- R5: Command 0x10, issued while idle in the program role, raises `busy_o` for 16 cycles per byte. During that time `cs_no` stays low and the link carries 0x02, then the address, then 128 data bytes. After that `busy_o` falls by itself.
- R6: Command 0x10 issued in the read role is ignored: no frame is sent and `busy_o` stays low.
- R7: The address goes out most significant byte first. With `addr4b_i`=0 it is the three bytes of bits 23:0. With `addr4b_i`=1 it is all four bytes.
- R8: Command 0x90, issued while idle in either role, sends 0x02, the address and `wdata_i` (the value sampled at the command). Afterwards the current address increases by one.
- R9: The page write position returns to byte 0 when the role changes from read to program and when a page program completes. Bytes that have not been rewritten keep their old values.
- R10: Command values other than 0x10 and 0x90 are ignored. Commands, address loads and role changes that arrive while busy are also ignored.
- R11: Each bit takes one cycle with `sclk_o` low, when `mosi_o` may change, then one cycle with `sclk_o` high, when `mosi_o` holds. `sclk_o` is high only while `cs_no` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_prog_i | input | 1 | Requested role: 1 program, 0 read prefetch |
| mode_ack_o | output | 1 | Role in effect |
| word_we_i | input | 1 | Page word write strobe |
| word_i | input | 32 | Page word, lowest byte in bits 7:0 |
| addr_ld_i | input | 1 | Load the current address |
| addr_i | input | ADDR_W | Address value to load |
| addr4b_i | input | 1 | Send four address bytes instead of three |
| wdata_i | input | 8 | Byte for the single-byte command |
| cmd_we_i | input | 1 | Command strobe |
| cmd_i | input | 8 | Command value: 0x10 page, 0x90 single byte |
| busy_o | output | 1 | A command is in progress |
| cs_no | output | 1 | Flash chip select, active low |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the flash |

## Verification
Three full pages are programmed. The first uses a three-byte address and an ascending pattern, which shows whether the bytes within each word are in the right order. The second uses a four-byte address and writes 33 words, which separates a correct frame length and address width from a 33rd word that overwrites byte 0. The third writes only half a page after a detour through the read role, in which it writes words and issues commands that must be dropped. Its frame must then combine fresh bytes with the previous page's upper half, which shows that the position rewinds while storage is kept. Single-byte commands back to back, and a flood of commands and address loads during a busy transfer, show that the address increments and that nothing interrupts a frame in flight.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam logic [7:0] CMD_PAGE  = 8'h10;
  localparam logic [7:0] CMD_BYTE  = 8'h90;
  localparam logic [7:0] FLASH_PROG_OP = 8'h02;
  typedef enum logic {K_PAGE, K_BYTE} kind_e;
endpackage

// File: rtl/pp_buf.sv
module pp_buf #(
  parameter int WORDS = 32,
  localparam int BYTES = WORDS * 4,
  localparam int BIDX_W = $clog2(BYTES),
  localparam int PTR_W = $clog2(WORDS) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [31:0]       word_i,
  input  logic [BIDX_W-1:0] rd_idx_i,
  output logic [7:0]        rd_byte_o
);
  logic [31:0] mem_q [WORDS];
  logic [PTR_W-1:0] ptr_q;
  logic wr_ok;
  logic [31:0] rd_word, rd_sh;

  assign wr_ok = we_i && (ptr_q < PTR_W'(WORDS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (clr_i) ptr_q <= '0;
    else if (wr_ok) ptr_q <= ptr_q + PTR_W'(1);
  end

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[ptr_q[PTR_W-2:0]] <= word_i;
  end

  // little-endian lane select
  assign rd_word   = mem_q[rd_idx_i[BIDX_W-1:2]];
  assign rd_sh     = rd_word >> {rd_idx_i[1:0], 3'b000};
  assign rd_byte_o = rd_sh[7:0];
endmodule

// File: rtl/pp_ctrl.sv
module pp_ctrl
  import pp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PAGE_BYTES = 128,
  localparam int BIDX_W = $clog2(PAGE_BYTES),
  localparam int TOT_W = $clog2(PAGE_BYTES + 6)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [7:0]        cmd_i,
  input  logic              role_i,
  input  logic              addr_ld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              addr4b_i,
  input  logic [7:0]        wdata_i,
  output logic [BIDX_W-1:0] rd_idx_o,
  input  logic [7:0]        rd_byte_i,
  output logic              busy_o,
  output logic              page_done_o,
  output logic              cs_no,
  output logic              sclk_o,
  output logic              mosi_o
);
  localparam logic [TOT_W-1:0] ONE = TOT_W'(1);

  logic              busy_q, phase_q;
  kind_e             kind_q;
  logic [2:0]        alen_q, bit_q;
  logic [TOT_W-1:0]  byte_q, total_q;
  logic [7:0]        sh_q, wdata_q, nxt;
  logic [ADDR_W-1:0] addr_q, ash;
  logic [TOT_W-1:0]  nidx, didx;
  logic [2:0]        k, alen_d;
  logic              accept, last, fin;

  assign accept = !busy_q && cmd_we_i &&
                  ((cmd_i == CMD_PAGE && role_i) || cmd_i == CMD_BYTE);
  assign alen_d = addr4b_i ? 3'd4 : 3'd3;
  assign last   = byte_q == total_q - ONE;
  assign fin    = busy_q && phase_q && bit_q == 3'd7 && last;

  // next byte of the frame: address MSB first, then data
  always_comb begin
    nidx = byte_q + ONE;
    k    = alen_q - nidx[2:0];
    ash  = addr_q >> {k, 3'b000};
    didx = nidx - TOT_W'(alen_q) - ONE;
    rd_idx_o = didx[BIDX_W-1:0];
    if (nidx <= TOT_W'(alen_q)) nxt = ash[7:0];
    else if (kind_q == K_PAGE)  nxt = rd_byte_i;
    else                        nxt = wdata_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      kind_q  <= K_PAGE;
      alen_q  <= 3'd3;
      bit_q   <= '0;
      byte_q  <= '0;
      total_q <= '0;
      sh_q    <= '0;
      wdata_q <= '0;
      addr_q  <= '0;
    end else if (!busy_q) begin
      if (addr_ld_i) addr_q <= addr_i;
      if (accept) begin
        busy_q  <= 1'b1;
        phase_q <= 1'b0;
        bit_q   <= '0;
        byte_q  <= '0;
        sh_q    <= FLASH_PROG_OP;
        alen_q  <= alen_d;
        wdata_q <= wdata_i;
        kind_q  <= (cmd_i == CMD_PAGE) ? K_PAGE : K_BYTE;
        total_q <= (cmd_i == CMD_PAGE) ? TOT_W'(PAGE_BYTES + 1) + TOT_W'(alen_d)
                                       : TOT_W'(2) + TOT_W'(alen_d);
      end
    end else begin
      phase_q <= !phase_q;
      if (phase_q) begin
        if (bit_q == 3'd7) begin
          bit_q <= '0;
          if (last) begin
            busy_q <= 1'b0;
            if (kind_q == K_BYTE) addr_q <= addr_q + ADDR_W'(1);
          end else begin
            byte_q <= nidx;
            sh_q   <= nxt;
          end
        end else begin
          bit_q <= bit_q + 3'd1;
          sh_q  <= {sh_q[6:0], 1'b0};
        end
      end
    end
  end

  assign page_done_o = fin && kind_q == K_PAGE;
  assign busy_o = busy_q;
  assign cs_no  = !busy_q;
  assign sclk_o = busy_q && phase_q;
  assign mosi_o = busy_q && sh_q[7];
endmodule

// File: rtl/pp_wbuf.sv
module pp_wbuf #(
  parameter int ADDR_W = 32,
  parameter int PAGE_WORDS = 32,
  localparam int PAGE_BYTES = PAGE_WORDS * 4,
  localparam int BIDX_W = $clog2(PAGE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_prog_i,
  output logic              mode_ack_o,
  input  logic              word_we_i,
  input  logic [31:0]       word_i,
  input  logic              addr_ld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              addr4b_i,
  input  logic [7:0]        wdata_i,
  input  logic              cmd_we_i,
  input  logic [7:0]        cmd_i,
  output logic              busy_o,
  output logic              cs_no,
  output logic              sclk_o,
  output logic              mosi_o
);
  logic role_q, busy, set_prog, page_done;
  logic [BIDX_W-1:0] rd_idx;
  logic [7:0] rd_byte;

  assign set_prog = !busy && mode_prog_i && !role_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) role_q <= 1'b0;
    else if (!busy) role_q <= mode_prog_i;
  end

  pp_buf #(.WORDS(PAGE_WORDS)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (set_prog || page_done),
    .we_i      (word_we_i && role_q && !busy),
    .word_i    (word_i),
    .rd_idx_i  (rd_idx),
    .rd_byte_o (rd_byte)
  );

  pp_ctrl #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_we_i    (cmd_we_i),
    .cmd_i       (cmd_i),
    .role_i      (role_q),
    .addr_ld_i   (addr_ld_i),
    .addr_i      (addr_i),
    .addr4b_i    (addr4b_i),
    .wdata_i     (wdata_i),
    .rd_idx_o    (rd_idx),
    .rd_byte_i   (rd_byte),
    .busy_o      (busy),
    .page_done_o (page_done),
    .cs_no       (cs_no),
    .sclk_o      (sclk_o),
    .mosi_o      (mosi_o)
  );

  assign busy_o     = busy;
  assign mode_ack_o = role_q;
endmodule

// File: rtl/pp_wbuf_chk.sv
module pp_wbuf_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sclk_o,
  input logic       mosi_o,
  input logic       cs_no,
  input logic       busy_o,
  input logic       mode_ack_o,
  input logic       cmd_we_i,
  input logic [7:0] cmd_i
);
  // R11
  sclk_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_no);
  // R11
  sclk_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |=> !sclk_o);
  // R11
  mosi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(mosi_o));
  // R2
  role_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(mode_ack_o));
  // R6
  page_in_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !mode_ack_o && cmd_we_i && cmd_i == 8'h10) |=> !busy_o);
  // R10
  bad_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cmd_we_i && cmd_i != 8'h10 && cmd_i != 8'h90) |=> !busy_o);
endmodule

bind pp_wbuf pp_wbuf_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sclk_o     (sclk_o),
  .mosi_o     (mosi_o),
  .cs_no      (cs_no),
  .busy_o     (busy_o),
  .mode_ack_o (mode_ack_o),
  .cmd_we_i   (cmd_we_i),
  .cmd_i      (cmd_i)
);

// File: tb/sim_pp_wbuf.sv
module sim_pp_wbuf;
  localparam int CLK_PERIOD = 10;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic mode_prog_i = 1'b0, word_we_i = 1'b0, addr_ld_i = 1'b0, addr4b_i = 1'b0;
  logic cmd_we_i = 1'b0;
  logic [31:0] word_i = '0, addr_i = '0;
  logic [7:0] wdata_i = '0, cmd_i = '0;
  logic mode_ack_o, busy_o, cs_no, sclk_o, mosi_o;

  int checks = 0, errors = 0, frames = 0;
  string ftag = "R5";

  // reference model state
  byte unsigned mem_m [128];
  int ptr_m = 0, busy_cnt = 0;
  bit role_m = 0, kind_byte_m = 0;
  logic [31:0] addr_m = '0;
  byte unsigned exp_q [$];
  byte unsigned cap_q [$];

  always #(CLK_PERIOD/2) clk_i = !clk_i;

  pp_wbuf u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // cycle model, updated at each rising edge
  always @(posedge clk_i) begin
    if (rst_ni) begin
      if (busy_cnt > 0) begin
        if (busy_cnt == 1) begin
          if (kind_byte_m) addr_m = addr_m + 1;
          else ptr_m = 0;
        end
        busy_cnt = busy_cnt - 1;
      end else begin
        if (word_we_i && role_m && ptr_m < 32) begin
          for (int j = 0; j < 4; j++) mem_m[ptr_m*4+j] = word_i[8*j +: 8];
          ptr_m++;
        end
        if (addr_ld_i) addr_m = addr_i;
        if (cmd_we_i && ((cmd_i == 8'h10 && role_m) || cmd_i == 8'h90)) begin
          int alen;
          alen = addr4b_i ? 4 : 3;
          exp_q.delete();
          exp_q.push_back(8'h02);
          for (int a = alen - 1; a >= 0; a--) exp_q.push_back(addr_m[8*a +: 8]);
          if (cmd_i == 8'h10) begin
            for (int b = 0; b < 128; b++) exp_q.push_back(mem_m[b]);
            kind_byte_m = 0;
          end else begin
            exp_q.push_back(wdata_i);
            kind_byte_m = 1;
          end
          busy_cnt = exp_q.size() * 16;
        end
        if (mode_prog_i && !role_m) ptr_m = 0;
        role_m = mode_prog_i;
      end
    end
  end

  // per-clock comparison and serial capture
  logic prev_sclk = 1'b0, prev_cs = 1'b1;
  logic [7:0] sh = '0;
  int nb = 0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk(busy_o == (busy_cnt != 0), "R5 busy", busy_o, busy_cnt != 0);
      chk(mode_ack_o == role_m, "R2 role ack", mode_ack_o, role_m);
      chk(!(sclk_o && cs_no), "R11 sclk outside frame", sclk_o, 0);
      if (!cs_no && prev_cs) begin nb = 0; cap_q.delete(); end
      if (!cs_no && sclk_o && !prev_sclk) begin
        sh = {sh[6:0], mosi_o};
        nb++;
        if (nb == 8) begin cap_q.push_back(sh); nb = 0; end
      end
      if (cs_no && !prev_cs) begin
        int bad;
        bad = -1;
        frames++;
        chk(cap_q.size() == exp_q.size(), {ftag, " frame length"}, cap_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < cap_q.size(); i++)
          if (bad < 0 && cap_q[i] != exp_q[i]) bad = i;
        if (bad >= 0) chk(0, {ftag, " frame byte"}, {bad[15:0], 8'h0, cap_q[bad]}, {bad[15:0], 8'h0, exp_q[bad]});
        else chk(1, ftag, 0, 0);
      end
      prev_sclk = sclk_o;
      prev_cs = cs_no;
    end
  end

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic put_word(input logic [31:0] w);
    word_i = w; word_we_i = 1'b1; cyc(); word_we_i = 1'b0;
  endtask

  task automatic set_addr(input logic [31:0] a, input bit four);
    addr_i = a; addr4b_i = four; addr_ld_i = 1'b1; cyc(); addr_ld_i = 1'b0;
  endtask

  task automatic issue(input logic [7:0] c);
    cmd_i = c; cmd_we_i = 1'b1; cyc(); cmd_we_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_o) cyc();
    cyc(2);
  endtask

  initial begin
    cyc(2);
    // R1
    chk(busy_o == 0 && cs_no == 1 && sclk_o == 0 && mode_ack_o == 0, "R1 reset", {busy_o, cs_no, sclk_o, mode_ack_o}, 4'b0100);
    rst_ni = 1'b1;
    cyc();
    chk(busy_o == 0 && cs_no == 1, "R1 after reset", {busy_o, cs_no}, 2'b01);

    // R2 role switch
    mode_prog_i = 1'b1; cyc();
    chk(mode_ack_o == 1, "R2 ack rise", mode_ack_o, 1);

    // R3 R5 R7: ascending page, 3-byte address
    ftag = "R3 R5 R7 page 3B";
    for (int w = 0; w < 32; w++)
      put_word({8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)});
    set_addr(32'h0012_3456, 0);
    issue(8'h10);
    wait_idle();
    chk(frames == 1, "R5 frame count", frames, 1);

    // R4 R7 R9: 33 words, 4-byte address; 33rd word dropped
    ftag = "R4 R7 R9 page 4B";
    for (int w = 0; w < 33; w++) put_word(32'hA5C3_0000 ^ (w * 32'h0101_0107));
    set_addr(32'hA1B2_C3D4, 1);
    issue(8'h10);
    // R10: commands, loads and role change during a frame are ignored
    cyc(20);
    issue(8'h90); set_addr(32'h0, 0); mode_prog_i = 1'b0; cyc(); mode_prog_i = 1'b1;
    issue(8'h10);
    wait_idle();
    chk(frames == 2, "R10 frame count", frames, 2);

    // R6 R4: read role drops words and page command
    mode_prog_i = 1'b0; cyc(2);
    for (int w = 0; w < 16; w++) put_word(32'hDEAD_0000 + w);
    issue(8'h10);
    cyc(40);
    chk(frames == 2 && busy_o == 0, "R6 no frame in read role", frames, 2);
    // R10 unknown command
    issue(8'h55);
    cyc(40);
    chk(frames == 2, "R10 unknown command", frames, 2);

    // R9: back to program, half page rewrites bytes 0..63
    ftag = "R9 R4 partial page";
    mode_prog_i = 1'b1; cyc();
    for (int w = 0; w < 16; w++) put_word(32'h1357_9BDF + w * 32'h1111_0000);
    set_addr(32'h0000_0100, 0);
    issue(8'h10);
    wait_idle();

    // R8: single bytes, address increments, read role allowed
    ftag = "R8 single byte";
    mode_prog_i = 1'b0; cyc();
    set_addr(32'h0000_10FE, 0);
    wdata_i = 8'h5A; issue(8'h90); wdata_i = 8'h00;
    wait_idle();
    ftag = "R8 single byte incremented";
    wdata_i = 8'hC3; issue(8'h90);
    wait_idle();
    ftag = "R8 R7 single byte 4B";
    addr4b_i = 1'b1; wdata_i = 8'h81; issue(8'h90);
    wait_idle();
    chk(frames == 6, "R8 frame count", frames, 6);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule